// File: doc/BRIEF.md
# Uncore clock frequency governor

This block picks the frequency ratio for the shared non-core clock domain of a multicore chip: the ring, the last-level cache slices and the link agents. It watches the ratio code each core is running at and a per-core flag that marks a core as parked in its enhanced idle state. From these it forms a target ratio. In dynamic mode the target follows the fastest awake core, and a bias bit chooses between a power-saving policy and a performance policy. A maximum-ratio mode, or a separate override, pins the domain at the configured ceiling.

The output ratio does not jump to the target. On each periodic update tick it moves one ratio step toward the target, so the clock generator downstream only ever sees single-step changes. A busy flag stays high for as long as the output and the target differ. Every target is clamped to a configured minimum and maximum ratio, and the output leaves reset at the maximum ratio.

Top module: `uncore_ratio_gov`

## Requirements
- R1: In the first cycle after reset the output ratio equals max_ratio.
- R2: In dynamic mode with the power bias (perf_bias=0), the target equals the highest ratio among cores whose idle flag is 0. Core i's ratio sits in core_ratio[i*RW +: RW].
- R3: In dynamic mode with the performance bias (perf_bias=1), the target is one above the fastest awake core, capped at max_ratio.
- R4: Cores with their idle flag at 1 are left out of the maximum. When every core is idle, the target is min_ratio.
- R5: When mode_max is 1, the target is max_ratio whatever the core ratios, idle flags and bias.
- R6: When override_en is 1, scaling is disabled and the target is max_ratio, even in dynamic mode.
- R7: Every target is clamped to the range [min_ratio, max_ratio].
- R8: The output ratio changes only on a cycle with tick high, and by exactly one step toward the target. It does not change when it already equals the target.
- R9: busy is 1 exactly when the output ratio differs from the current target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Periodic update strobe |
| core_ratio | input | NCORES*RW | Packed per-core ratio codes; core i at [i*RW +: RW] |
| core_idle | input | NCORES | Per-core enhanced-idle flags |
| mode_max | input | 1 | 1 selects maximum mode, 0 selects dynamic mode |
| override_en | input | 1 | 1 disables scaling and pins the ratio at max_ratio |
| perf_bias | input | 1 | 1 selects the performance policy, 0 the power policy |
| min_ratio | input | RW | Configured floor ratio |
| max_ratio | input | RW | Configured ceiling ratio |
| uncore_ratio | output | RW | Current uncore ratio code |
| busy | output | 1 | High while uncore_ratio differs from the target |

## Verification
The assertions watch the stepping rules on every cycle. They check that the ratio holds between ticks, that it moves by exactly one step toward the target on a tick, and that it stays still when busy is low. They also check that maximum mode, the override and the all-idle case each force the target they call for. How the target is chosen is shown by the bench's scenarios, which walk the ratio through several settings: the fastest awake core under each bias, the exclusion of idle cores, the clamp at both bounds and the reset value.

// File: rtl/uncore_ratio_gov.sv
module uncore_ratio_gov #(
  parameter int NCORES = 4,
  parameter int RW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NCORES*RW-1:0] core_ratio,
  input  logic [NCORES-1:0] core_idle,
  input  logic              mode_max,
  input  logic              override_en,
  input  logic              perf_bias,
  input  logic [RW-1:0]     min_ratio,
  input  logic [RW-1:0]     max_ratio,
  output logic [RW-1:0]     uncore_ratio,
  output logic              busy
);

  localparam int EW = RW + 1;

  logic [RW-1:0] fastest;
  logic          any_awake;
  logic [EW-1:0] want;
  logic [RW-1:0] target;
  logic [RW-1:0] ratio_q;

  always_comb begin
    fastest   = '0;
    any_awake = 1'b0;
    for (int i = 0; i < NCORES; i++) begin
      if (!core_idle[i]) begin
        any_awake = 1'b1;
        if (core_ratio[i*RW +: RW] > fastest) fastest = core_ratio[i*RW +: RW];
      end
    end
  end

  always_comb begin
    if (mode_max || override_en)  want = {1'b0, max_ratio};
    else if (!any_awake)          want = {1'b0, min_ratio};
    else                          want = {1'b0, fastest} + EW'(perf_bias);
    if (want > {1'b0, max_ratio})      target = max_ratio;
    else if (want < {1'b0, min_ratio}) target = min_ratio;
    else                               target = want[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             ratio_q <= max_ratio;
    else if (tick && ratio_q < target)      ratio_q <= ratio_q + 1'b1;
    else if (tick && ratio_q > target)      ratio_q <= ratio_q - 1'b1;
  end

  assign uncore_ratio = ratio_q;
  assign busy         = (ratio_q != target);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ratio_q)); // R8
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_q < target) |=> ratio_q == $past(ratio_q) + 1'b1); // R8
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_q > target) |=> ratio_q == $past(ratio_q) - 1'b1); // R8
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ratio_q)); // R9
  AST_MAX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_max |-> target == max_ratio); // R5
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    override_en |-> target == max_ratio); // R6
  AST_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_max && !override_en && (&core_idle) && min_ratio <= max_ratio) |-> target == min_ratio); // R4

endmodule

// File: tb/uncore_ratio_gov_tb.sv
module uncore_ratio_gov_tb;
  localparam int NCORES = 4;
  localparam int RW     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NCORES*RW-1:0] core_ratio = '0;
  logic [NCORES-1:0] core_idle = '1;
  logic mode_max = 1'b0, override_en = 1'b0, perf_bias = 1'b0;
  logic [RW-1:0] min_ratio = 6'd8, max_ratio = 6'd30;
  logic [RW-1:0] uncore_ratio;
  logic busy;

  int checks = 0, errors = 0, cycles = 0;
  logic [RW-1:0] exp_ratio;
  logic [RW-1:0] q_ratio[$];
  logic          q_busy[$];
  string         q_tag[$];

  always #2 clk = ~clk;

  uncore_ratio_gov #(.NCORES(NCORES), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .core_ratio(core_ratio),
    .core_idle(core_idle), .mode_max(mode_max), .override_en(override_en),
    .perf_bias(perf_bias), .min_ratio(min_ratio), .max_ratio(max_ratio),
    .uncore_ratio(uncore_ratio), .busy(busy));

  function automatic logic [RW-1:0] model_target();
    int best = -1;
    int w;
    if (mode_max || override_en) return max_ratio;
    for (int i = 0; i < NCORES; i++)
      if (!core_idle[i] && int'(core_ratio[i*RW +: RW]) > best) best = int'(core_ratio[i*RW +: RW]);
    if (best < 0) return min_ratio;
    w = best + (perf_bias ? 1 : 0);
    if (w > int'(max_ratio)) w = int'(max_ratio);
    if (w < int'(min_ratio)) w = int'(min_ratio);
    return RW'(w);
  endfunction

  task automatic set_cores(input int r0, input int r1, input int r2, input int r3, input logic [3:0] idle);
    core_ratio = {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
    core_idle  = idle;
  endtask

  task automatic drive(input logic t, input string tag);
    logic [RW-1:0] tg;
    @(negedge clk);
    tick = t;
    tg = model_target();
    if (t && exp_ratio < tg) exp_ratio = exp_ratio + 1'b1;
    else if (t && exp_ratio > tg) exp_ratio = exp_ratio - 1'b1;
    q_ratio.push_back(exp_ratio);
    q_busy.push_back(exp_ratio != tg);
    q_tag.push_back(tag);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) drive(1'b1, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_ratio.size() > 0) begin
        logic [RW-1:0] er;
        logic eb;
        string tg;
        er = q_ratio.pop_front();
        eb = q_busy.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (uncore_ratio !== er || busy !== eb) begin
          errors++;
          $display("FAIL %s: ratio=%0d busy=%0b expected ratio=%0d busy=%0b", tg, uncore_ratio, busy, er, eb);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    exp_ratio = max_ratio;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, "R1 reset value");
    set_cores(12, 20, 15, 10, 4'b0000);
    run_ticks(12, "R2 power bias follows fastest core");
    drive(1'b0, "R8 hold without tick");
    perf_bias = 1'b1;
    run_ticks(2, "R3 performance bias one above");
    drive(1'b0, "R9 settled not busy");
    set_cores(12, 20, 15, 10, 4'b0010);
    run_ticks(6, "R4 idle core excluded");
    set_cores(12, 20, 15, 10, 4'b1111);
    run_ticks(10, "R4 all idle gives minimum");
    set_cores(40, 20, 29, 10, 4'b0000);
    run_ticks(24, "R7 clamp at maximum");
    perf_bias = 1'b0;
    set_cores(3, 2, 1, 5, 4'b0000);
    run_ticks(24, "R7 clamp at minimum");
    mode_max = 1'b1;
    run_ticks(3, "R5 max mode pins high");
    drive(1'b0, "R9 busy while stepping");
    run_ticks(20, "R5 max mode reaches ceiling");
    mode_max = 1'b0;
    run_ticks(4, "R8 one step toward lower target");
    override_en = 1'b1;
    run_ticks(6, "R6 override pins high");
    run_ticks(2, "R6 override held at ceiling");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule